// File: doc/BRIEF.md
# MII Frame Transmit Serializer

This block turns a byte stream of frames into the signals of a 4-bit MII transmit interface. The byte stream arrives on a valid/ready handshake with start-of-frame, end-of-frame and error markers. Each accepted byte goes out as two nibbles on consecutive rising clock edges, low nibble first. The transmit enable frames the whole packet. If the source flags a frame as bad, the transmit error line carries a single one-cycle pulse inside the frame.

The block accepts at most one byte every two clock cycles. It lowers `in_ready` in every cycle where a byte could not be taken at the next edge. After each frame it holds the enable low for a configurable minimum number of idle cycles. If the source runs dry in the middle of a frame, the block closes the frame. It marks the truncation on the line unless the frame already carries an error pulse. The rest of that frame is then thrown away, because those bytes have no start marker. Preamble, start delimiter, CRC, inter-frame gap policy beyond the minimum, and collision handling all sit outside this block.

Top module: `mii_tx_serializer`

## Requirements
- R1: While `rst_n` is low, `mii_txen`, `mii_txer` and `mii_txd` are all zero. In the first cycle after reset is released, `in_ready` is high and `mii_txen` is low.
- R2: Each accepted byte appears on `mii_txd` as two consecutive nibbles: bits [3:0] in the first cycle, then bits [7:4] in the next.
- R3: A frame of N bytes, supplied without a pause, drives `mii_txen` high for exactly 2N consecutive cycles. The first nibble appears in the cycle after the start byte is accepted.
- R4: Between frames, `mii_txen` is low for at least MIN_GAP cycles, and `mii_txd` reads zero whenever `mii_txen` is low. If the next start byte is already waiting, the gap is exactly MIN_GAP cycles.
- R5: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the first nibble of a byte is on the line. During the second nibble, `in_ready` is high unless that byte ends the frame. Inside a frame, bytes are therefore taken at most once every two cycles.
- R6: If `in_err` is high with any byte of a frame, including the last byte, `mii_txer` is high for exactly one cycle in that frame. That cycle is the first nibble of the earliest flagged byte. Flagging further bytes adds no pulse, and the data nibbles are unchanged.
- R7: `mii_txer` is never high while `mii_txen` is low.
- R8: A byte accepted while idle with `in_sop` low is consumed and has no effect. No enable, data or error appears, and `in_ready` stays high.
- R9: Suppose `in_valid` is low at the edge where the next byte of an unfinished frame is due. If the frame has not yet pulsed `mii_txer`, one extra cycle follows with `mii_txen`=1, `mii_txer`=1 and `mii_txd`=0, and then the line goes idle. If the frame has already pulsed, the frame ends after the current byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Source presents a byte |
| in_ready | output | 1 | Block takes the byte at the next rising edge |
| in_data | input | DATA_W (8) | Byte to send |
| in_sop | input | 1 | Byte opens a frame |
| in_eop | input | 1 | Byte closes a frame |
| in_err | input | 1 | Frame is flagged bad (any byte) |
| mii_txd | output | NIB_W (4) | Transmit nibble |
| mii_txen | output | 1 | Transmit enable, high across the frame |
| mii_txer | output | 1 | Transmit error, one-cycle pulse |

## Verification
The bench sweeps frame lengths from one to six bytes with the error flag placed on every byte in turn. In some frames a second, later byte is flagged as well. A design that held the error as a level, repeated it for a second flagged byte, or dropped a flag on the closing byte would show a wrong pulse count or position. Frames run back to back so that an off-by-one in the idle gap or in the ready timing shows up as a gap length other than MIN_GAP or as a wrong frame length. Source starvation is exercised with and without an earlier error pulse. A design that added a second pulse, skipped the truncation marker, or started a frame from the orphaned trailing bytes would be caught.

// File: rtl/mii_tx_pkg.sv
// Package: shared types for the MII transmit serializer.
package mii_tx_pkg;

    // Line activity of the serializer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // enable low, waiting for a start byte
        ST_SEND  = 2'd1,   // a byte's nibbles are on the line
        ST_ABORT = 2'd2    // single truncation-marker cycle
    } tx_state_e;

endpackage

// File: rtl/mtx_gap_timer.sv
// Module: mtx_gap_timer
// Counts idle cycles after a frame and reports when the minimum gap has
// elapsed. Assumes MIN_GAP >= 1. Restarting loads one, because the
// cycle that starts right after the restart edge is already idle.
module mtx_gap_timer #(
    parameter int MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic idle_tick,
    output logic gap_done
);
    localparam int CNT_W = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_GAP);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Saturating idle-cycle counter, full after reset so the first frame is not delayed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MAX;
        end else if (restart) begin
            cnt_q <= CNT_ONE;
        end else if (idle_tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign gap_done = (cnt_q == CNT_MAX);
endmodule

// File: rtl/mtx_nibble_path.sv
// Module: mtx_nibble_path
// Holds the byte being sent and drives the registered nibble bus.
// Loading puts nibble zero on the bus at once; advancing selects the lane
// named by next_idx. In any other cycle the bus reads zero. Assumes
// DATA_W is a multiple of NIB_W.
module mtx_nibble_path #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    clk,
    rst_n,
    load,
    advance,
    load_byte,
    next_idx,
    txd
);
    localparam int NIB_CNT = DATA_W / NIB_W;
    localparam int IDX_W   = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1;

    input  logic              clk;
    input  logic              rst_n;
    input  logic              load;
    input  logic              advance;
    input  logic [DATA_W-1:0] load_byte;
    input  logic [IDX_W-1:0]  next_idx;
    output logic [NIB_W-1:0]  txd;

    logic [DATA_W-1:0] byte_q;
    logic [NIB_W-1:0]  nib_lane [NIB_CNT];
    logic [NIB_W-1:0]  txd_q;

    // Split the held byte into nibble lanes, least significant lane first
    for (genvar g = 0; g < NIB_CNT; g++) begin : g_lane
        assign nib_lane[g] = byte_q[g*NIB_W +: NIB_W];
    end

    // Capture the byte when the control accepts it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (load) begin
            byte_q <= load_byte;
        end
    end

    // Drive the line nibble: first lane on load, chosen lane on advance, else zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_q <= '0;
        end else if (load) begin
            txd_q <= load_byte[NIB_W-1:0];
        end else if (advance) begin
            txd_q <= nib_lane[next_idx];
        end else begin
            txd_q <= '0;
        end
    end

    assign txd = txd_q;
endmodule

// File: rtl/mtx_err_map.sv
// Module: mtx_err_map
// Turns the per-byte error flag into a single registered error pulse
// per frame, issued with the first nibble of the earliest flagged byte.
// It also drives the truncation marker. A per-frame flag remembers that
// a pulse went out; a frame start clears it. Assumes abort_go is raised
// only while pulsed is low.
module mtx_err_map (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic frame_start,
    input  logic err_in,
    input  logic abort_go,
    output logic txer,
    output logic pulsed
);
    logic fire;
    logic pulsed_q;
    logic txer_q;

    // A flagged byte fires only if the frame has no pulse yet
    always_comb begin
        fire = load && err_in && (frame_start || !pulsed_q);
    end

    // Track whether the current frame has already shown its pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulsed_q <= 1'b0;
        end else if (frame_start) begin
            pulsed_q <= fire;
        end else if (fire || abort_go) begin
            pulsed_q <= 1'b1;
        end
    end

    // Register the error line together with the nibble it belongs to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txer_q <= 1'b0;
        end else begin
            txer_q <= fire || abort_go;
        end
    end

    assign txer   = txer_q;
    assign pulsed = pulsed_q;
endmodule

// File: rtl/mii_tx_serializer.sv
// Module: mii_tx_serializer
// Byte-stream to 4-bit MII transmit serializer. A small control state
// machine decides, cycle by cycle, whether the line idles, shows a data
// nibble or shows a truncation marker. The submodules hold the data
// path, the error mapping and the inter-frame gap. All outputs come from
// registers and change on the rising clock edge. Assumes DATA_W/NIB_W >= 2
// and MIN_GAP >= 1.
module mii_tx_serializer #(
    parameter int DATA_W  = 8,
    parameter int NIB_W   = 4,
    parameter int MIN_GAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_err,
    output logic [NIB_W-1:0]  mii_txd,
    output logic              mii_txen,
    output logic              mii_txer
);
    import mii_tx_pkg::*;

    localparam int NIB_CNT = DATA_W / NIB_W;
    localparam int IDX_W   = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NIB_CNT - 1);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    tx_state_e        state_q, state_d;
    logic [IDX_W-1:0] nib_q, nib_d;
    logic             eop_q, eop_d;
    logic             txen_q;

    logic gap_done;
    logic pulsed;
    logic last_nib;
    logic accept;
    logic frame_start;
    logic byte_next;
    logic load;
    logic advance;
    logic underrun;
    logic abort_go;
    logic gap_restart;
    logic ready_c;

    // Handshake and event decode from the current line state
    always_comb begin
        last_nib    = (nib_q == IDX_LAST);
        ready_c     = ((state_q == ST_IDLE) && gap_done) ||
                      ((state_q == ST_SEND) && last_nib && !eop_q);
        accept      = in_valid && ready_c;
        frame_start = accept && (state_q == ST_IDLE) && in_sop;
        byte_next   = accept && (state_q == ST_SEND);
        load        = frame_start || byte_next;
        advance     = (state_q == ST_SEND) && !last_nib;
        underrun    = (state_q == ST_SEND) && last_nib && !eop_q && !in_valid;
        abort_go    = underrun && !pulsed;
    end

    // Next line state, nibble index and end-of-frame memory
    always_comb begin
        state_d = state_q;
        nib_d   = nib_q;
        eop_d   = eop_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) begin
                    state_d = ST_SEND;
                    nib_d   = '0;
                    eop_d   = in_eop;
                end
            end
            ST_SEND: begin
                if (advance) begin
                    nib_d = nib_q + IDX_ONE;
                end else if (byte_next) begin
                    nib_d = '0;
                    eop_d = in_eop;
                end else if (abort_go) begin
                    state_d = ST_ABORT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ABORT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        gap_restart = (state_q != ST_IDLE) && (state_d == ST_IDLE);
    end

    // Control registers and the registered enable line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nib_q   <= '0;
            eop_q   <= 1'b0;
            txen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            nib_q   <= nib_d;
            eop_q   <= eop_d;
            txen_q  <= (state_d != ST_IDLE);
        end
    end

    mtx_gap_timer #(
        .MIN_GAP (MIN_GAP)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (gap_restart),
        .idle_tick (state_q == ST_IDLE),
        .gap_done  (gap_done)
    );

    mtx_nibble_path #(
        .DATA_W (DATA_W),
        .NIB_W  (NIB_W)
    ) u_nib (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .load_byte (in_data),
        .next_idx  (nib_d),
        .txd       (mii_txd)
    );

    mtx_err_map u_err (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .frame_start (frame_start),
        .err_in      (in_err),
        .abort_go    (abort_go),
        .txer        (mii_txer),
        .pulsed      (pulsed)
    );

    assign in_ready = ready_c;
    assign mii_txen = txen_q;
endmodule

// File: rtl/mii_tx_serializer_chk.sv
// Module: mii_tx_serializer_chk
// Port-level protocol checker for the serializer, attached by bind.
// It counts idle cycles, saturating at 255 (so it assumes MIN_GAP < 255),
// and remembers whether the current frame has shown an error pulse.
module mii_tx_serializer_chk #(
    parameter int MIN_GAP = 2
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_sop,
    input logic mii_txen,
    input logic mii_txer
);
    logic       err_seen;
    logic [7:0] idle_cnt;

    // Observation state: idle run length and per-frame error memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_seen <= 1'b0;
            idle_cnt <= 8'hFF;
        end else begin
            if (!mii_txen) begin
                err_seen <= 1'b0;
            end else if (mii_txer) begin
                err_seen <= 1'b1;
            end
            if (mii_txen) begin
                idle_cnt <= 8'd0;
            end else if (idle_cnt != 8'hFF) begin
                idle_cnt <= idle_cnt + 8'd1;
            end
        end
    end

    AST_ERR_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mii_txer |-> mii_txen); // R7

    AST_ONE_ERR_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mii_txer |-> !err_seen); // R6

    AST_MIN_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_txen) |-> (int'(idle_cnt) >= MIN_GAP)); // R4

    AST_NO_READY_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mii_txen && (int'(idle_cnt) + 1 < MIN_GAP)) |-> !in_ready); // R4

    AST_ACCEPT_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_sop || mii_txen)) |=> mii_txen); // R5

    AST_FIRST_NIBBLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_txen) |-> !in_ready); // R5
endmodule

bind mii_tx_serializer mii_tx_serializer_chk #(
    .MIN_GAP (MIN_GAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_sop   (in_sop),
    .mii_txen (mii_txen),
    .mii_txer (mii_txer)
);

// File: tb/mii_tx_serializer_tb.sv
`timescale 1ns/1ps
module mii_tx_serializer_tb;
    localparam int DATA_W  = 8;
    localparam int NIB_W   = 4;
    localparam int MIN_GAP = 2;
    localparam int CAP_MAX = 2048;
    localparam int FR_MAX  = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic             in_sop = 1'b0;
    logic             in_eop = 1'b0;
    logic             in_err = 1'b0;
    logic [NIB_W-1:0] mii_txd;
    logic             mii_txen;
    logic             mii_txer;

    int checks = 0;
    int fails  = 0;

    logic [3:0] cap_d [CAP_MAX];
    logic       cap_e [CAP_MAX];
    int cap_n = 0;
    int fr_start [FR_MAX];
    int fr_len   [FR_MAX];
    int fr_gap   [FR_MAX];
    int fr_n = 0;
    int idle_run = 0;
    logic prev_en = 1'b0;
    int bad_err = 0;
    int bad_idle_data = 0;

    int exp_len   [FR_MAX];
    int exp_errpos[FR_MAX];

    always #4 clk = ~clk;

    mii_tx_serializer #(
        .DATA_W  (DATA_W),
        .NIB_W   (NIB_W),
        .MIN_GAP (MIN_GAP)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_err   (in_err),
        .mii_txd  (mii_txd),
        .mii_txen (mii_txen),
        .mii_txer (mii_txer)
    );

    // Line monitor: records frames, gaps and idle-time misbehaviour
    always @(negedge clk) begin
        if (rst_n) begin
            if (mii_txen) begin
                if (!prev_en && fr_n < FR_MAX) begin
                    fr_start[fr_n] = cap_n;
                    fr_gap[fr_n]   = idle_run;
                end
                if (cap_n < CAP_MAX) begin
                    cap_d[cap_n] = mii_txd;
                    cap_e[cap_n] = mii_txer;
                    cap_n++;
                end
            end else begin
                if (prev_en && fr_n < FR_MAX) begin
                    fr_len[fr_n] = cap_n - fr_start[fr_n];
                    fr_n++;
                    idle_run = 0;
                end
                idle_run++;
                if (mii_txer) bad_err++;
                if (mii_txd != 4'd0) bad_idle_data++;
            end
            prev_en = mii_txen;
        end
    end

    function automatic logic [7:0] byte_val(input int f, input int i);
        return 8'((f * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic s, input logic e, input logic r);
        in_data  = d;
        in_sop   = s;
        in_eop   = e;
        in_err   = r;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_frames(input int n);
        int t;
        t = 0;
        while (fr_n < n && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (MIN_GAP + 4) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        int nf;
        int k;
        int mism;
        int errs;
        int epos;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1", "txen in reset", int'(mii_txen), 0);
        check_eq("R1", "txer in reset", int'(mii_txer), 0);
        check_eq("R1", "txd in reset", int'(mii_txd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "ready after reset", int'(in_ready), 1);
        check_eq("R1", "txen after reset", int'(mii_txen), 0);

        // R8: byte without start marker while idle is dropped
        push(8'hA5, 1'b0, 1'b1, 1'b1);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        check_eq("R8", "frames after orphan byte", fr_n, 0);
        check_eq("R8", "nibbles after orphan byte", cap_n, 0);
        check_eq("R8", "ready after orphan byte", int'(in_ready), 1);

        // Sweep: lengths 1..6, error on each byte or none, back to back
        base = fr_n;
        nf = 0;
        for (int len = 1; len <= 6; len++) begin
            for (int ep = -1; ep < len; ep++) begin
                exp_len[nf]    = len;
                exp_errpos[nf] = (ep < 0) ? -1 : 2 * ep;
                for (int i = 0; i < len; i++) begin
                    push(byte_val(nf, i), (i == 0), (i == len - 1),
                         (i == ep) || (ep >= 0 && len > 2 && i == len - 1));
                end
                nf++;
            end
        end
        in_valid = 1'b0;
        in_err   = 1'b0;
        wait_frames(base + nf);
        check_eq("R3", "sweep frame count", fr_n - base, nf);
        for (int f = 0; f < nf; f++) begin
            k = base + f;
            check_eq("R3", $sformatf("frame %0d enable length", f), fr_len[k], 2 * exp_len[f]);
            mism = 0;
            errs = 0;
            epos = -1;
            for (int n = 0; n < 2 * exp_len[f]; n++) begin
                logic [7:0] b;
                logic [3:0] en;
                b  = byte_val(f, n / 2);
                en = (n % 2 == 0) ? b[3:0] : b[7:4];
                if (cap_d[fr_start[k] + n] != en) mism++;
                if (cap_e[fr_start[k] + n]) begin
                    errs++;
                    if (epos < 0) epos = n;
                end
            end
            check_eq("R2", $sformatf("frame %0d nibble mismatches", f), mism, 0);
            check_eq("R6", $sformatf("frame %0d error pulses", f), errs, (exp_errpos[f] < 0) ? 0 : 1);
            check_eq("R6", $sformatf("frame %0d error position", f), epos, exp_errpos[f]);
            if (f > 0) begin
                check_eq("R4", $sformatf("gap before frame %0d", f), fr_gap[k], MIN_GAP);
            end
        end

        // R9 and R5: starvation with no earlier error pulse
        base = fr_n;
        push(8'h3C, 1'b1, 1'b0, 1'b0);
        check_eq("R5", "ready on first nibble", int'(in_ready), 0);
        in_valid = 1'b0;
        @(negedge clk);
        check_eq("R5", "ready on second nibble", int'(in_ready), 1);
        @(negedge clk);
        push(8'h77, 1'b0, 1'b1, 1'b0);
        in_valid = 1'b0;
        wait_frames(base + 1);
        check_eq("R9", "abort frame count", fr_n - base, 1);
        check_eq("R9", "abort frame length", fr_len[base], 3);
        check_eq("R9", "abort nibble0", int'(cap_d[fr_start[base]]), 4'hC);
        check_eq("R9", "abort nibble1", int'(cap_d[fr_start[base] + 1]), 4'h3);
        check_eq("R9", "abort marker data", int'(cap_d[fr_start[base] + 2]), 0);
        check_eq("R9", "abort marker err", int'(cap_e[fr_start[base] + 2]), 1);
        check_eq("R9", "no err before marker",
                 int'(cap_e[fr_start[base]]) + int'(cap_e[fr_start[base] + 1]), 0);
        repeat (10) @(negedge clk);
        check_eq("R8", "trailing bytes dropped", fr_n - base, 1);

        // R9: starvation after the frame already pulsed
        base = fr_n;
        push(8'h5A, 1'b1, 1'b0, 1'b1);
        in_valid = 1'b0;
        in_err   = 1'b0;
        wait_frames(base + 1);
        check_eq("R9", "pulsed starve length", fr_len[base], 2);
        check_eq("R9", "pulsed starve nibble0", int'(cap_d[fr_start[base]]), 4'hA);
        check_eq("R9", "pulsed starve nibble1", int'(cap_d[fr_start[base] + 1]), 4'h5);
        check_eq("R6", "pulsed starve err first", int'(cap_e[fr_start[base]]), 1);
        check_eq("R6", "pulsed starve err second", int'(cap_e[fr_start[base] + 1]), 0);

        // R7 and R4: idle-time line cleanliness over the whole run
        check_eq("R7", "txer while enable low", bad_err, 0);
        check_eq("R4", "nonzero data while enable low", bad_idle_data, 0);

        summary();
        $finish;
    end
endmodule